// File: doc/BRIEF.md
# Dual-Pair Lockstep Failover Controller

This block supervises four processors that run the same program in lockstep, grouped as two pairs with one pair per device. Each cycle it compares the two members of each pair. While both pairs agree, the system output is taken from pair A. If exactly one pair disagrees, the output switches to the agreeing pair in the same cycle, so the system sees no outage. The failed pair is then halted.

The controller then steps through a recovery sequence. It waits for an external opportunity signal and asks for the upset device to be reconfigured. It holds that request until the reconfiguration reports completion. It then releases the halted pair and asks for its state to be reloaded from the healthy pair. It goes back to four-way lockstep once all four outputs have agreed for a set number of consecutive cycles. A reboot request is raised, and held until reset, in any of these cases: both pairs disagree in the same cycle, the healthy pair fails during recovery, or the reconfiguration never acknowledges.

Top module: `lockstepPairSelector`

## Requirements
- R1: With no disagreement in the locked mode, `sysOut` equals `pairA0Out`, both halts are low, and `modeCode` stays 0.
- R2: In the locked mode, if exactly one pair's members differ, `sysOut` equals the agreeing pair's member 0 in that same cycle. From the next cycle, `modeCode` is 1 (only A running, B failed) or 2 (only B running, A failed), and the failed pair's halt is high.
- R3: Mode 1 or 2 moves to waiting (`modeCode` 3) after one cycle. Waiting holds until `reconfigWindow` is high, and `reconfigDone` has no effect there. `reconfigWindow` has no effect in the locked mode.
- R4: In the reconfigure mode (`modeCode` 4), `reconfigReq` is high and `reconfigTarget` names the failed pair (0 = A, 1 = B). The mode is left for resync (`modeCode` 5) on the edge where `reconfigDone` is high.
- R5: If `reconfigDone` has not arrived within ACK_TIMEOUT cycles of reconfigure mode, the block enters reboot (`modeCode` 6).
- R6: In resync, both halts are low and `resyncReq` is high. The block returns to the locked mode after SYNC_CYCLES consecutive cycles in which all four inputs are equal. Any cycle with a disagreement restarts that count.
- R7: If both pairs disagree in the same locked cycle, `sysOut` is 0 in that cycle and reboot follows on the next cycle.
- R8: If the healthy pair disagrees in modes 1 to 5, the block enters reboot on the next cycle. Until then, `sysOut` shows the healthy pair's member 0.
- R9: Reboot is held until reset. In reboot, `rebootReq` and both halts are high and `sysOut` is 0.
- R10: After reset, `modeCode` is 0, `reconfigReq`, `resyncReq`, `rebootReq` and both halts are low, and `sysOut` follows `pairA0Out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pairA0Out | input | DATA_W | Output of processor 0 of pair A |
| pairA1Out | input | DATA_W | Output of processor 1 of pair A |
| pairB0Out | input | DATA_W | Output of processor 0 of pair B |
| pairB1Out | input | DATA_W | Output of processor 1 of pair B |
| reconfigWindow | input | 1 | Reconfiguration may start now |
| reconfigDone | input | 1 | Reconfiguration of the failed device is complete |
| sysOut | output | DATA_W | Selected system output |
| haltA | output | 1 | Stop pair A |
| haltB | output | 1 | Stop pair B |
| reconfigReq | output | 1 | Request reconfiguration of the failed device |
| reconfigTarget | output | 1 | Failed pair: 0 = A, 1 = B |
| resyncReq | output | 1 | Reload the failed pair from the healthy pair |
| rebootReq | output | 1 | Full reboot needed |
| modeCode | output | 3 | Current mode, 0 to 6 as above |

## Verification
The hardest situations to reach are the late failures. These are a reconfiguration that never acknowledges, and a second fault in the healthy pair during resync. Both exist only after a full chain of one-sided fault, waiting and reconfiguration. The stimulus table walks that chain step by step, including a broken run of agreement inside resync. Directed sequences then rebuild the chain after a reset and withhold the acknowledge for exactly the timeout window.

// File: rtl/lockstepPairPkg.sv
package lockstepPairPkg;

  typedef enum logic [2:0] {
    ST_ALL_LOCKED = 3'd0,
    ST_RUN_A_ONLY = 3'd1,
    ST_RUN_B_ONLY = 3'd2,
    ST_WAIT_OPP   = 3'd3,
    ST_RECONFIG   = 3'd4,
    ST_RESYNC     = 3'd5,
    ST_REBOOT     = 3'd6
  } lockMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selB;        // route pair B member 0 to the output
    logic zeroOut;     // force the output to zero
    logic ackCntRun;   // count reconfigure cycles, clear when low
    logic syncCntRun;  // count agreeing resync cycles, clear when low
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic misA;
    logic misB;
    logic allEqual;
    logic ackExpired;
    logic syncReached;
  } dpStatus_t;

endpackage

// File: rtl/lockstepPairDatapath.sv
module lockstepPairDatapath
  import lockstepPairPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_CYCLES = 3,
  parameter int ACK_TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pairA0Out,
  input  logic [DATA_W-1:0] pairA1Out,
  input  logic [DATA_W-1:0] pairB0Out,
  input  logic [DATA_W-1:0] pairB1Out,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic [DATA_W-1:0] sysOut
);

  localparam int ACK_W  = $clog2(ACK_TIMEOUT + 1);
  localparam int SYNC_W = $clog2(SYNC_CYCLES + 1);
  localparam int NPAIR  = 2;

  logic [DATA_W-1:0] memberOut [NPAIR][2];
  logic [NPAIR-1:0]  pairMis;
  logic [ACK_W-1:0]  ackCnt;
  logic [SYNC_W-1:0] syncCnt;

  assign memberOut[0][0] = pairA0Out;
  assign memberOut[0][1] = pairA1Out;
  assign memberOut[1][0] = pairB0Out;
  assign memberOut[1][1] = pairB1Out;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pairCmp
    assign pairMis[p] = memberOut[p][0] != memberOut[p][1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ackCnt <= '0;
    else if (!strobe.ackCntRun) ackCnt <= '0;
    else                       ackCnt <= ackCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  syncCnt <= '0;
    else if (!strobe.syncCntRun) syncCnt <= '0;
    else                        syncCnt <= syncCnt + 1'b1;
  end

  always_comb begin
    status.misA        = pairMis[0];
    status.misB        = pairMis[1];
    status.allEqual    = !pairMis[0] && !pairMis[1] && (pairA0Out == pairB0Out);
    status.ackExpired  = ackCnt == ACK_W'(ACK_TIMEOUT - 1);
    status.syncReached = syncCnt == SYNC_W'(SYNC_CYCLES - 1);
  end

  always_comb begin
    if (strobe.zeroOut)   sysOut = '0;
    else if (strobe.selB) sysOut = memberOut[1][0];
    else                  sysOut = memberOut[0][0];
  end

endmodule

// File: rtl/lockstepPairControl.sv
module lockstepPairControl
  import lockstepPairPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  input  logic        reconfigWindow,
  input  logic        reconfigDone,
  output ctrlStrobe_t strobe,
  output logic        haltA,
  output logic        haltB,
  output logic        reconfigReq,
  output logic        reconfigTarget,
  output logic        resyncReq,
  output logic        rebootReq,
  output logic [2:0]  modeCode
);

  lockMode_e mode, modeNext;
  logic      badSide, badSideNext;   // 0: pair A failed, 1: pair B failed
  logic      degraded, healthyMis, holdFailed;

  assign degraded   = mode inside {ST_RUN_A_ONLY, ST_RUN_B_ONLY, ST_WAIT_OPP,
                                   ST_RECONFIG, ST_RESYNC};
  assign healthyMis = badSide ? status.misA : status.misB;
  assign holdFailed = mode inside {ST_RUN_A_ONLY, ST_RUN_B_ONLY, ST_WAIT_OPP, ST_RECONFIG};

  always_comb begin
    modeNext    = mode;
    badSideNext = badSide;
    unique case (mode)
      ST_ALL_LOCKED: begin
        if (status.misA && status.misB) modeNext = ST_REBOOT;
        else if (status.misA) begin
          modeNext    = ST_RUN_B_ONLY;
          badSideNext = 1'b0;
        end else if (status.misB) begin
          modeNext    = ST_RUN_A_ONLY;
          badSideNext = 1'b1;
        end
      end
      ST_RUN_A_ONLY, ST_RUN_B_ONLY: modeNext = healthyMis ? ST_REBOOT : ST_WAIT_OPP;
      ST_WAIT_OPP: begin
        if (healthyMis)          modeNext = ST_REBOOT;
        else if (reconfigWindow) modeNext = ST_RECONFIG;
      end
      ST_RECONFIG: begin
        if (healthyMis)             modeNext = ST_REBOOT;
        else if (reconfigDone)      modeNext = ST_RESYNC;
        else if (status.ackExpired) modeNext = ST_REBOOT;
      end
      ST_RESYNC: begin
        if (healthyMis) modeNext = ST_REBOOT;
        else if (status.allEqual && status.syncReached) modeNext = ST_ALL_LOCKED;
      end
      ST_REBOOT: modeNext = ST_REBOOT;
      default:   modeNext = ST_REBOOT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode    <= ST_ALL_LOCKED;
      badSide <= 1'b0;
    end else begin
      mode    <= modeNext;
      badSide <= badSideNext;
    end
  end

  always_comb begin
    strobe.selB       = (mode == ST_ALL_LOCKED) ? (status.misA && !status.misB)
                                                : (degraded && !badSide);
    strobe.zeroOut    = (mode == ST_REBOOT) ||
                        ((mode == ST_ALL_LOCKED) && status.misA && status.misB);
    strobe.ackCntRun  = mode == ST_RECONFIG;
    strobe.syncCntRun = (mode == ST_RESYNC) && status.allEqual;
  end

  assign haltA          = (holdFailed && !badSide) || (mode == ST_REBOOT);
  assign haltB          = (holdFailed && badSide) || (mode == ST_REBOOT);
  assign reconfigReq    = mode == ST_RECONFIG;
  assign reconfigTarget = badSide;
  assign resyncReq      = mode == ST_RESYNC;
  assign rebootReq      = mode == ST_REBOOT;
  assign modeCode       = mode;

endmodule

// File: rtl/lockstepPairSelector.sv
module lockstepPairSelector
  import lockstepPairPkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_CYCLES = 3,
  parameter int ACK_TIMEOUT = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] pairA0Out,
  input  logic [DATA_W-1:0] pairA1Out,
  input  logic [DATA_W-1:0] pairB0Out,
  input  logic [DATA_W-1:0] pairB1Out,
  input  logic              reconfigWindow,
  input  logic              reconfigDone,
  output logic [DATA_W-1:0] sysOut,
  output logic              haltA,
  output logic              haltB,
  output logic              reconfigReq,
  output logic              reconfigTarget,
  output logic              resyncReq,
  output logic              rebootReq,
  output logic [2:0]        modeCode
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  lockstepPairDatapath #(
    .DATA_W(DATA_W), .SYNC_CYCLES(SYNC_CYCLES), .ACK_TIMEOUT(ACK_TIMEOUT)
  ) datapath_i (
    .clk(clk), .rstN(rstN),
    .pairA0Out(pairA0Out), .pairA1Out(pairA1Out),
    .pairB0Out(pairB0Out), .pairB1Out(pairB1Out),
    .strobe(strobe), .status(status), .sysOut(sysOut)
  );

  lockstepPairControl control_i (
    .clk(clk), .rstN(rstN), .status(status),
    .reconfigWindow(reconfigWindow), .reconfigDone(reconfigDone),
    .strobe(strobe), .haltA(haltA), .haltB(haltB),
    .reconfigReq(reconfigReq), .reconfigTarget(reconfigTarget),
    .resyncReq(resyncReq), .rebootReq(rebootReq), .modeCode(modeCode)
  );

endmodule

// File: rtl/lockstepPairSelectorChk.sv
module lockstepPairSelectorChk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] pairA0Out,
  input logic [DATA_W-1:0] pairA1Out,
  input logic [DATA_W-1:0] pairB0Out,
  input logic [DATA_W-1:0] pairB1Out,
  input logic              reconfigWindow,
  input logic              reconfigDone,
  input logic              haltA,
  input logic              haltB,
  input logic              reconfigReq,
  input logic [2:0]        modeCode
);

  logic fourAgree;
  assign fourAgree = (pairA0Out == pairA1Out) && (pairA0Out == pairB0Out) &&
                     (pairA0Out == pairB1Out);

  assert_reboot_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    modeCode == 3'd6 |=> modeCode == 3'd6);

  assert_one_halt_degraded_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode inside {3'd1, 3'd2, 3'd3, 3'd4}) |-> $countones({haltA, haltB}) == 1);

  assert_req_after_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reconfigReq) |-> $past(reconfigWindow));

  assert_resync_after_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd5 && $past(modeCode) == 3'd4) |-> $past(reconfigDone));

  assert_timeout_without_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd6 && $past(modeCode) == 3'd4) |-> !$past(reconfigDone));

  assert_relock_on_agree_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode == 3'd0 && $past(modeCode) == 3'd5) |-> $past(fourAgree));

endmodule

bind lockstepPairSelector lockstepPairSelectorChk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN),
  .pairA0Out(pairA0Out), .pairA1Out(pairA1Out),
  .pairB0Out(pairB0Out), .pairB1Out(pairB1Out),
  .reconfigWindow(reconfigWindow), .reconfigDone(reconfigDone),
  .haltA(haltA), .haltB(haltB), .reconfigReq(reconfigReq), .modeCode(modeCode)
);

// File: tb/lockstepPairSelector_tb_top.sv
module lockstepPairSelector_tb_top;

  localparam int DATA_W      = 16;
  localparam int SYNC_CYCLES = 3;
  localparam int ACK_TIMEOUT = 8;
  localparam int ROWS        = 21;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
  logic win = 1'b0, done = 1'b0;
  logic [DATA_W-1:0] sysOut;
  logic haltA, haltB, reconfigReq, reconfigTarget, resyncReq, rebootReq;
  logic [2:0] modeCode;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;   // 50 MHz

  lockstepPairSelector #(
    .DATA_W(DATA_W), .SYNC_CYCLES(SYNC_CYCLES), .ACK_TIMEOUT(ACK_TIMEOUT)
  ) dut_i (
    .clk(clk), .rstN(rstN),
    .pairA0Out(a0), .pairA1Out(a1), .pairB0Out(b0), .pairB1Out(b1),
    .reconfigWindow(win), .reconfigDone(done),
    .sysOut(sysOut), .haltA(haltA), .haltB(haltB),
    .reconfigReq(reconfigReq), .reconfigTarget(reconfigTarget),
    .resyncReq(resyncReq), .rebootReq(rebootReq), .modeCode(modeCode)
  );

  typedef struct packed {
    logic [3:0] reqNo;
    logic [7:0] va0, va1, vb0, vb1;
    logic       vWin, vDone;
    logic [2:0] eMode;
    logic [7:0] eOut;
    logic       eHaltA, eHaltB, eReq, eReboot;
  } vec_t;

  // inputs applied, outputs checked before the edge; mode is the state entering the edge
  localparam vec_t TBL [ROWS] = '{
    '{4'd1, 8'd5, 8'd5, 8'd5, 8'd5, 1'b0, 1'b0, 3'd0, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0}, // R1
    '{4'd1, 8'd7, 8'd7, 8'd7, 8'd9, 1'b0, 1'b0, 3'd0, 8'd7, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 B fails
    '{4'd2, 8'd8, 8'd8, 8'd1, 8'd2, 1'b0, 1'b0, 3'd1, 8'd8, 1'b0, 1'b1, 1'b0, 1'b0}, // R2
    '{4'd3, 8'd9, 8'd9, 8'd3, 8'd3, 1'b0, 1'b1, 3'd3, 8'd9, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 done ignored
    '{4'd3, 8'd4, 8'd4, 8'd0, 8'd0, 1'b1, 1'b0, 3'd3, 8'd4, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 window
    '{4'd4, 8'd6, 8'd6, 8'd0, 8'd0, 1'b0, 1'b0, 3'd4, 8'd6, 1'b0, 1'b1, 1'b1, 1'b0}, // R4
    '{4'd4, 8'd6, 8'd6, 8'd0, 8'd0, 1'b0, 1'b1, 3'd4, 8'd6, 1'b0, 1'b1, 1'b1, 1'b0}, // R4 done
    '{4'd6, 8'd2, 8'd2, 8'd3, 8'd3, 1'b0, 1'b0, 3'd5, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd6, 8'd2, 8'd2, 8'd2, 8'd2, 1'b0, 1'b0, 3'd5, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 count 1
    '{4'd6, 8'd2, 8'd2, 8'd2, 8'd2, 1'b0, 1'b0, 3'd5, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 count 2
    '{4'd6, 8'd2, 8'd2, 8'd2, 8'd5, 1'b0, 1'b0, 3'd5, 8'd2, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 restart
    '{4'd6, 8'd3, 8'd3, 8'd3, 8'd3, 1'b0, 1'b0, 3'd5, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd6, 8'd3, 8'd3, 8'd3, 8'd3, 1'b0, 1'b0, 3'd5, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd6, 8'd3, 8'd3, 8'd3, 8'd3, 1'b0, 1'b0, 3'd5, 8'd3, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 relock
    '{4'd2, 8'd1, 8'd6, 8'd4, 8'd4, 1'b0, 1'b0, 3'd0, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 same cycle
    '{4'd2, 8'd0, 8'd0, 8'd4, 8'd4, 1'b0, 1'b0, 3'd2, 8'd4, 1'b1, 1'b0, 1'b0, 1'b0}, // R2
    '{4'd3, 8'd0, 8'd0, 8'd5, 8'd5, 1'b1, 1'b0, 3'd3, 8'd5, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    '{4'd4, 8'd0, 8'd0, 8'd5, 8'd5, 1'b0, 1'b1, 3'd4, 8'd5, 1'b1, 1'b0, 1'b1, 1'b0}, // R4
    '{4'd6, 8'd5, 8'd5, 8'd5, 8'd5, 1'b0, 1'b0, 3'd5, 8'd5, 1'b0, 1'b0, 1'b0, 1'b0}, // R6
    '{4'd8, 8'd5, 8'd5, 8'd6, 8'd7, 1'b0, 1'b0, 3'd5, 8'd6, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    '{4'd9, 8'd5, 8'd5, 8'd5, 8'd5, 1'b0, 1'b0, 3'd6, 8'd0, 1'b1, 1'b1, 1'b0, 1'b1}  // R9
  };

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic setIn(input int va0, input int va1, input int vb0, input int vb1,
                       input logic w, input logic d);
    a0 = DATA_W'(va0); a1 = DATA_W'(va1); b0 = DATA_W'(vb0); b1 = DATA_W'(vb1);
    win = w; done = d;
    #1;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    setIn(11, 11, 11, 11, 1'b0, 1'b0);
    step();
    rstN = 1'b1;
    #1;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    string rq;
    doReset();
    // R10 reset values
    check("R10", "mode", modeCode, 0);
    check("R10", "sysOut", sysOut, 11);
    check("R10", "halts", {haltA, haltB}, 0);
    check("R10", "requests", {reconfigReq, resyncReq, rebootReq}, 0);

    for (int i = 0; i < ROWS; i++) begin
      setIn(TBL[i].va0, TBL[i].va1, TBL[i].vb0, TBL[i].vb1, TBL[i].vWin, TBL[i].vDone);
      rq = $sformatf("R%0d row %0d", TBL[i].reqNo, i);
      check(rq, "mode", modeCode, TBL[i].eMode);
      check(rq, "sysOut", sysOut, TBL[i].eOut);
      check(rq, "haltA", haltA, TBL[i].eHaltA);
      check(rq, "haltB", haltB, TBL[i].eHaltB);
      check(rq, "reconfigReq", reconfigReq, TBL[i].eReq);
      check(rq, "rebootReq", rebootReq, TBL[i].eReboot);
      check(rq, "resyncReq", resyncReq, TBL[i].eMode == 3'd5);
      step();
    end

    // R9 reboot persists with agreeing inputs
    setIn(5, 5, 5, 5, 1'b1, 1'b1);
    step(); step();
    check("R9", "mode held", modeCode, 6);

    // R3 window ignored while locked
    doReset();
    setIn(4, 4, 4, 4, 1'b1, 1'b0);
    step();
    check("R3", "mode after window", modeCode, 0);
    check("R3", "reconfigReq", reconfigReq, 0);

    // R7 double failure
    setIn(1, 2, 3, 4, 1'b0, 1'b0);
    check("R7", "sysOut zero", sysOut, 0);
    step();
    check("R7", "mode", modeCode, 6);

    // R5 acknowledge timeout, pair B failed
    doReset();
    setIn(3, 3, 3, 8, 1'b0, 1'b0);
    step();
    setIn(3, 3, 0, 0, 1'b0, 1'b0);
    step();
    check("R3", "wait mode", modeCode, 3);
    check("R4", "target B", reconfigTarget, 1);
    setIn(3, 3, 0, 0, 1'b1, 1'b0);
    step();
    setIn(3, 3, 0, 0, 1'b0, 1'b0);
    for (int k = 0; k < ACK_TIMEOUT; k++) begin
      check("R5", "still reconfig", modeCode, 4);
      step();
    end
    check("R5", "reboot on timeout", modeCode, 6);
    check("R9", "both halted", {haltA, haltB}, 3);

    finishRun();
  end

endmodule